// File: doc/BRIEF.md
# Unpadded Streaming Window Line Buffer

This block turns a raster pixel stream, one pixel per clock with start-of-line, end-of-line, start-of-frame, end-of-frame and valid flags, into a K-by-K neighbourhood window. K is odd and fixed when the block is built. The window holds the newest K lines and the newest K columns of the stream. Frame edges get no padding. When the neighbourhood reaches past the image, the window is still produced on the normal pixel beat, but its contents are undefined. A downstream filter therefore consumes one window per accepted pixel and discards the border positions itself.

History lines are kept in register-built line memories. The depth of those memories is set by a maximum line width parameter. The write column restarts at zero on each start-of-line. A pixel is accepted only between start-of-line and end-of-line while valid is high. Each accepted pixel produces exactly one shift strobe in the following cycle. The internal latency does not depend on K, so the idle time needed between lines stays small and fixed. The flags of the window centre pixel travel beside the pixels. The output stream therefore has the same line and frame structure as the input, delayed by the centre lag.

Top module: `lb_unpad_win`

## Requirements
- R1: One cycle after an accepted pixel at line y, column x, window element (r, c) holds the input pixel at line y-r, column x-c. It sits at bits [(r*K+c)*DW +: DW] of `win_o`, with r=0 the newest line and c=0 the newest column. This holds for every interior position, y >= K-1 and x >= K-1.
- R2: A pixel is accepted when `vld_i` is high and either `hs_i` is high or an earlier start-of-line has not yet been closed by an accepted end-of-line. `shift_en_o` is high in exactly the cycle after each accepted pixel and low in every other cycle.
- R3: A valid pixel presented before start-of-line or after end-of-line is ignored. There is no shift strobe, the window is unchanged, the write column is unchanged and no output flag is raised.
- R4: A cycle with `vld_i` low in the middle of a line leaves the window unchanged and holds `shift_en_o` low. The line then continues at the next column.
- R5: In a shift cycle, `{hs_o,he_o,vs_o,ve_o,vld_o}` equals the flags of the pixel accepted D = (K/2)*W + K/2 accepted pixels earlier, where W is the active line width. Before D pixels have been accepted since reset, these outputs are zero. No output flag is raised outside a shift cycle.
- R6: Twelve idle cycles between lines are enough for any K. Border windows are still produced, one per accepted pixel.
- R7: The write column restarts at zero on every accepted start-of-line, so column x of each line lines up with column x of the lines stored before it.
- R8: While reset is held and right after it is released, `shift_en_o` and all output flags are low and the window is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_i | input | DW | Input pixel |
| vld_i | input | 1 | Input pixel valid |
| hs_i | input | 1 | First pixel of a line |
| he_i | input | 1 | Last pixel of a line |
| vs_i | input | 1 | First pixel of a frame |
| ve_i | input | 1 | Last pixel of a frame |
| win_o | output | K*K*DW | Neighbourhood window, element (r,c) at [(r*K+c)*DW +: DW] |
| shift_en_o | output | 1 | Window advanced this cycle |
| vld_o | output | 1 | Centre pixel valid |
| hs_o | output | 1 | Centre pixel starts a line |
| he_o | output | 1 | Centre pixel ends a line |
| vs_o | output | 1 | Centre pixel starts a frame |
| ve_o | output | 1 | Centre pixel ends a frame |

## Verification
The bench streams several frames of a small 3-by-3 configuration and computes every interior window arithmetically. A design that reads the wrong line or column would show shifted pixels here. The bench inserts mid-line stalls and stray valid pixels outside the active line. A design that advanced on those cycles would shift the window and strobe `shift_en_o`. A design that let a stray pixel move the write column would misalign the next line, and the window checks would catch it. The bench compares the centre flags against a delayed copy of the input flags across frame boundaries, which exposes any error in the centre lag or in the gating by shift cycles.

// File: rtl/lb_pkg.sv
package lb_pkg;

  // Control flags carried beside every stored pixel.
  typedef struct packed {
    logic hs;
    logic he;
    logic vs;
    logic ve;
    logic vld;
  } lb_ctrl_t;

  // Rows (and columns) between the newest pixel and the window centre.
  function automatic int unsigned lb_half(input int unsigned k);
    return k / 2;
  endfunction

  // Accepted pixels between an input pixel and its appearance at the centre.
  function automatic int unsigned lb_centre_lag(input int unsigned k,
                                                input int unsigned w);
    return lb_half(k) * w + lb_half(k);
  endfunction

  // Write column used for the current pixel.
  function automatic int unsigned lb_wr_col(input logic hs,
                                            input int unsigned col);
    return hs ? 0 : col;
  endfunction

  // Column following the one just written, held at the last slot.
  function automatic int unsigned lb_next_col(input int unsigned col,
                                              input int unsigned maxw);
    return (col >= maxw - 1) ? col : col + 1;
  endfunction

endpackage

// File: rtl/lb_line_ctrl.sv
module lb_line_ctrl #(
  parameter int MAXW = 64,
  parameter int AW   = $clog2(MAXW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic          hs_i,
  input  logic          he_i,
  output logic          take_o,
  output logic [AW-1:0] wr_col_o,
  output logic [AW-1:0] col_q_o
);
  import lb_pkg::*;

  logic          in_line_q;
  logic [AW-1:0] col_q;

  // A pixel counts only inside the span from line start to line end.
  assign take_o   = vld_i & (hs_i | in_line_q);
  assign wr_col_o = AW'(lb_wr_col(hs_i, int'(col_q)));
  assign col_q_o  = col_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_line_q <= 1'b0;
      col_q     <= '0;
    end else if (take_o) begin
      in_line_q <= ~he_i;
      col_q     <= AW'(lb_next_col(int'(wr_col_o), MAXW));
    end
  end

endmodule

// File: rtl/lb_line_store.sv
module lb_line_store #(
  parameter int DW   = 8,
  parameter int K    = 3,
  parameter int MAXW = 64,
  parameter int AW   = $clog2(MAXW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [AW-1:0]    col_i,
  input  logic [DW-1:0]    pix_i,
  input  lb_pkg::lb_ctrl_t ctrl_i,
  output logic [K*DW-1:0]  col_pix_o,
  output lb_pkg::lb_ctrl_t cen_ctrl_o
);
  import lb_pkg::*;

  localparam int H  = lb_half(K);
  localparam int NL = K - 1;

  // Pixel history: entry j holds the line j+1 lines older than the input.
  logic [DW-1:0] pmem [NL][MAXW];
  // Flag history, needed only down to the centre row.
  lb_ctrl_t      cmem [H][MAXW];

  always_ff @(posedge clk) begin
    if (take_i) begin
      pmem[0][col_i] <= pix_i;
      for (int j = 1; j < NL; j++) pmem[j][col_i] <= pmem[j-1][col_i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < H; j++)
        for (int a = 0; a < MAXW; a++) cmem[j][a] <= '0;
    end else if (take_i) begin
      cmem[0][col_i] <= ctrl_i;
      for (int j = 1; j < H; j++) cmem[j][col_i] <= cmem[j-1][col_i];
    end
  end

  // Column vector: row 0 is the live pixel, row r the stored line r-1.
  for (genvar r = 0; r < K; r++) begin : g_col
    if (r == 0) begin : g_live
      assign col_pix_o[r*DW +: DW] = pix_i;
    end else begin : g_old
      assign col_pix_o[r*DW +: DW] = pmem[r-1][col_i];
    end
  end

  assign cen_ctrl_o = cmem[H-1][col_i];

endmodule

// File: rtl/lb_window.sv
module lb_window #(
  parameter int DW = 8,
  parameter int K  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [K*DW-1:0]   col_pix_i,
  input  lb_pkg::lb_ctrl_t  cen_ctrl_i,
  output logic [K*K*DW-1:0] win_o,
  output logic              shift_o,
  output lb_pkg::lb_ctrl_t  ctrl_o
);
  import lb_pkg::*;

  localparam int H = lb_half(K);

  logic [DW-1:0] win_q [K][K];
  lb_ctrl_t      cpipe_q [H+1];
  logic          shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < K; r++)
        for (int c = 0; c < K; c++) win_q[r][c] <= '0;
      for (int c = 0; c <= H; c++) cpipe_q[c] <= '0;
      shift_q <= 1'b0;
    end else begin
      shift_q <= take_i;
      if (take_i) begin
        for (int r = 0; r < K; r++) begin
          win_q[r][0] <= col_pix_i[r*DW +: DW];
          for (int c = 1; c < K; c++) win_q[r][c] <= win_q[r][c-1];
        end
        cpipe_q[0] <= cen_ctrl_i;
        for (int c = 1; c <= H; c++) cpipe_q[c] <= cpipe_q[c-1];
      end
    end
  end

  for (genvar r = 0; r < K; r++) begin : g_row
    for (genvar c = 0; c < K; c++) begin : g_cell
      assign win_o[(r*K+c)*DW +: DW] = win_q[r][c];
    end
  end

  assign shift_o = shift_q;
  // Centre flags appear only on the beat the window moves.
  assign ctrl_o  = shift_q ? cpipe_q[H] : '0;

endmodule

// File: rtl/lb_unpad_win.sv
module lb_unpad_win #(
  parameter int DW   = 8,
  parameter int K    = 3,
  parameter int MAXW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     pix_i,
  input  logic              vld_i,
  input  logic              hs_i,
  input  logic              he_i,
  input  logic              vs_i,
  input  logic              ve_i,
  output logic [K*K*DW-1:0] win_o,
  output logic              shift_en_o,
  output logic              vld_o,
  output logic              hs_o,
  output logic              he_o,
  output logic              vs_o,
  output logic              ve_o
);
  import lb_pkg::*;

  localparam int AW = $clog2(MAXW);

  // Named internal events, also watched by the bound checker.
  logic          take_w;
  logic [AW-1:0] wr_col_w;
  logic [AW-1:0] col_w;
  logic [K*DW-1:0] col_pix_w;
  lb_ctrl_t      in_ctrl_w;
  lb_ctrl_t      cen_ctrl_w;
  lb_ctrl_t      out_ctrl_w;

  assign in_ctrl_w = '{hs: hs_i, he: he_i, vs: vs_i, ve: ve_i, vld: 1'b1};

  lb_line_ctrl #(.MAXW(MAXW), .AW(AW)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (vld_i),
    .hs_i    (hs_i),
    .he_i    (he_i),
    .take_o  (take_w),
    .wr_col_o(wr_col_w),
    .col_q_o (col_w)
  );

  lb_line_store #(.DW(DW), .K(K), .MAXW(MAXW), .AW(AW)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take_w),
    .col_i     (wr_col_w),
    .pix_i     (pix_i),
    .ctrl_i    (in_ctrl_w),
    .col_pix_o (col_pix_w),
    .cen_ctrl_o(cen_ctrl_w)
  );

  lb_window #(.DW(DW), .K(K)) i_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take_w),
    .col_pix_i (col_pix_w),
    .cen_ctrl_i(cen_ctrl_w),
    .win_o     (win_o),
    .shift_o   (shift_en_o),
    .ctrl_o    (out_ctrl_w)
  );

  assign vld_o = out_ctrl_w.vld;
  assign hs_o  = out_ctrl_w.hs;
  assign he_o  = out_ctrl_w.he;
  assign vs_o  = out_ctrl_w.vs;
  assign ve_o  = out_ctrl_w.ve;

endmodule

// File: rtl/lb_unpad_win_chk.sv
module lb_unpad_win_chk #(
  parameter int DW = 8,
  parameter int K  = 3,
  parameter int AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              take_w,
  input logic              hs_i,
  input logic [AW-1:0]     col_w,
  input logic [K*K*DW-1:0] win_o,
  input logic              shift_en_o,
  input logic              vld_o,
  input logic              hs_o,
  input logic              he_o,
  input logic              vs_o,
  input logic              ve_o
);

  p_shift_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> shift_en_o);

  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !take_w |=> (!shift_en_o && $stable(win_o)));

  p_col_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !take_w |=> $stable(col_w));

  p_col_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && hs_i) |=> (col_w == AW'(1)));

  p_flags_in_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o || hs_o || he_o || vs_o || ve_o) |-> shift_en_o);

endmodule

bind lb_unpad_win lb_unpad_win_chk #(.DW(DW), .K(K), .AW(AW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .take_w    (take_w),
  .hs_i      (hs_i),
  .col_w     (col_w),
  .win_o     (win_o),
  .shift_en_o(shift_en_o),
  .vld_o     (vld_o),
  .hs_o      (hs_o),
  .he_o      (he_o),
  .vs_o      (vs_o),
  .ve_o      (ve_o)
);

// File: tb/test_lb_unpad_win.sv
module test_lb_unpad_win;
  localparam int CLK_NS = 10;
  localparam int DW   = 8;
  localparam int K    = 3;
  localparam int MAXW = 8;
  localparam int W    = 6;
  localparam int NLN  = 5;
  localparam int HK   = K / 2;
  localparam int D    = HK * W + HK;
  localparam int WW   = K * K * DW;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic [DW-1:0] pix_i = '0;
  logic vld_i = 1'b0, hs_i = 1'b0, he_i = 1'b0, vs_i = 1'b0, ve_i = 1'b0;
  logic [WW-1:0] win_o;
  logic shift_en_o, vld_o, hs_o, he_o, vs_o, ve_o;

  lb_unpad_win #(.DW(DW), .K(K), .MAXW(MAXW)) i_lb_unpad_win (
    .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .vld_i(vld_i),
    .hs_i(hs_i), .he_i(he_i), .vs_i(vs_i), .ve_i(ve_i),
    .win_o(win_o), .shift_en_o(shift_en_o), .vld_o(vld_o),
    .hs_o(hs_o), .he_o(he_o), .vs_o(vs_o), .ve_o(ve_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int acc   = 0;
  logic [4:0]    chist [256];
  logic [WW-1:0] prev_win = '0;

  function automatic logic [7:0] pixval(int f, int y, int x);
    return 8'((f * 37 + y * 11 + x * 3 + 1) % 256);
  endfunction

  task automatic check(bit ok, string req, string what,
                       logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic v, logic hs, logic he, logic vs, logic ve,
                       logic [7:0] p);
    @(negedge clk);
    vld_i = v; hs_i = hs; he_i = he; vs_i = vs; ve_i = ve; pix_i = p;
    @(posedge clk);
    #(CLK_NS/4);
  endtask

  // Cycle in which the window must not move (idle, stall or stray pixel).
  task automatic expect_hold(string req, logic v);
    drive(v, 1'b0, 1'b0, 1'b0, 1'b0, v ? 8'hEE : 8'h5A);
    check(shift_en_o == 1'b0, req, "shift_en_o", 128'(shift_en_o), 128'(0));
    check(win_o == prev_win, req, "window held", 128'(win_o), 128'(prev_win));
    check({hs_o, he_o, vs_o, ve_o, vld_o} == 5'b0, req, "flags",
          128'({hs_o, he_o, vs_o, ve_o, vld_o}), 128'(0));
  endtask

  task automatic put_pix(int f, int y, int x);
    logic hs, he, vs, ve;
    logic [4:0] exp_c;
    hs = (x == 0); he = (x == W-1);
    vs = (x == 0 && y == 0); ve = (x == W-1 && y == NLN-1);
    chist[acc % 256] = {hs, he, vs, ve, 1'b1};
    acc++;
    drive(1'b1, hs, he, vs, ve, pixval(f, y, x));
    check(shift_en_o == 1'b1, "R2", "shift_en_o", 128'(shift_en_o), 128'(1));
    exp_c = (acc - 1 >= D) ? chist[(acc - 1 - D) % 256] : 5'b0;
    check({hs_o, he_o, vs_o, ve_o, vld_o} == exp_c, "R5", "centre flags",
          128'({hs_o, he_o, vs_o, ve_o, vld_o}), 128'(exp_c));
    if (y >= K-1 && x >= K-1) begin
      for (int r = 0; r < K; r++)
        for (int c = 0; c < K; c++)
          check(win_o[(r*K+c)*DW +: DW] == pixval(f, y-r, x-c), "R1",
                "window element", 128'(win_o[(r*K+c)*DW +: DW]),
                128'(pixval(f, y-r, x-c)));
    end
    prev_win = win_o;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #(CLK_NS/4);
    // R8: reset state
    check(shift_en_o == 1'b0, "R8", "shift_en_o in reset", 128'(shift_en_o), 128'(0));
    check(win_o == '0, "R8", "window in reset", 128'(win_o), 128'(0));
    check({hs_o, he_o, vs_o, ve_o, vld_o} == 5'b0, "R8", "flags in reset",
          128'({hs_o, he_o, vs_o, ve_o, vld_o}), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_NS/4);
    check(shift_en_o == 1'b0, "R8", "shift_en_o after reset", 128'(shift_en_o), 128'(0));
    check(win_o == '0, "R8", "window after reset", 128'(win_o), 128'(0));

    for (int f = 0; f < 4; f++) begin
      for (int y = 0; y < NLN; y++) begin
        // R6: only twelve idle cycles between lines
        repeat (12) expect_hold("R6", 1'b0);
        // R3: stray valid pixel ahead of line start
        if (f == 2 && (y % 2) == 1) expect_hold("R3", 1'b1);
        for (int x = 0; x < W; x++) begin
          put_pix(f, y, x);
          // R4: mid-line stalls
          if (f == 1 && ((x + y) % 3) == 0 && x != W-1) begin
            expect_hold("R4", 1'b0);
            expect_hold("R4", 1'b0);
          end
        end
        // R3/R7: stray valid after line end must not move the column
        if (f == 2 && (y % 2) == 0) begin
          expect_hold("R3", 1'b1);
          expect_hold("R7", 1'b1);
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule